// File: doc/BRIEF.md
# Prescaled Timer with Dual Trigger Outputs

This block is an up-counting timer for a chip with many timers that start and gate one another. A clock prescaler divides the clock and drives a counter. The counter runs from zero up to a reload limit and then wraps. Each wrap is an update event. The time between update events is (prescale + 1) × (reload + 1) clock cycles. The prescale value and the reload limit each have a pending copy and an active copy. A control bit chooses whether a write reaches the active copy at once or waits for the next update event. A software command forces an update event at any time. It copies the pending values into the active copies and restarts the counter and the prescaler from zero.

Two independent selectors choose which internal event or level drives each trigger output. The primary selector has 8 codes. The secondary selector has 16 codes, which include single-edge and combined-edge events on six compare reference inputs. Other timers take the trigger outputs as their start or gate input. The secondary selector is optional. Software can detect it, because on a build without it the field always reads back as zero.

Top module: `trig_timer`

## Requirements
- R1: After reset every output is 0, every register reads 0 and the counter is stopped.
- R2: Register map (word address: content): 0 control with bit0 run, bit1 reload preload enable and bit2 prescale preload enable; 1 mode with primary code in bits [2:0] and secondary code in bits [7:4]; 2 prescale; 3 reload; 4 compare value; 5 command, where writing bit0 = 1 forces an update (reads 0); 6 counter (read only). While running, the counter advances once every prescale + 1 cycles and wraps from the active reload value to 0. Update events are therefore (prescale + 1) × (reload + 1) cycles apart.
- R3: When the reload preload bit is 1, a reload write changes only the pending copy, and the active limit takes the new value at the next update event. When the bit is 0, the write also takes effect on the same clock edge. A read always returns the pending copy.
- R4: The prescale register has the same preload behaviour, controlled by its own preload bit.
- R5: A forced update on the edge where the command is written sets the counter and the prescaler to 0 and loads both pending values into the active copies. Primary code 0 (reset) drives the trigger with forced updates only. Code 2 (update) drives it with forced updates and with wraps.
- R6: While run is 0 the counter holds its value. Primary code 1 (enable) drives the trigger as a level equal to run.
- R7: Trigger outputs are registered. Each output is high in the cycle after the cycle in which its selected source is true. Primary codes 4 to 7 pass reference inputs ref[0] to ref[3] as levels.
- R8: Code 3 (compare pulse) fires for one counter step when the counter is loaded with a value equal to the compare register. It rises one cycle after that load, and the trigger rises one cycle after that.
- R9: Secondary codes 0 to 7 mean the same as the primary codes. Codes 8 and 9 pass ref[4] and ref[5] as levels. Codes 10 and 11 pulse on a rising edge of ref[3] and of ref[5].
- R10: Secondary codes 12 to 15 pulse on rise ref[3] OR rise ref[5], rise ref[3] OR fall ref[5], rise ref[4] OR rise ref[5], and rise ref[4] OR fall ref[5]. Edges are judged against the reference value of the previous cycle.
- R11: With HAS_SEL2 = 0 the secondary field reads back 0 after any write, and the secondary trigger output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write word address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 3 | Read word address |
| rdData | output | DATA_W | Read data (combinational) |
| ocRef | input | 6 | Compare reference inputs ref[0]..ref[5] |
| count | output | CNT_W | Current counter value |
| trgo | output | 1 | Primary trigger output |
| trgo2 | output | 1 | Secondary trigger output |

## Verification
The bench builds the main instance with an 8-bit counter and a 4-bit prescaler. With these widths a full-scale reload of 255 completes within a few hundred cycles. Random prescale values that are lower than the running prescaler also reach the prescaler's natural wrap quickly. A second instance, built with HAS_SEL2 = 0 and fed the same stimulus, shows the discovery behaviour next to the full build. Random stimulus often writes reload or prescale in the same cycle as a wrap. This exercises the ordering between an immediate write and a shadow reload.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int REF_N  = 6;
  localparam int SRC_N  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic run;
    logic rldPre;
    logic pscPre;
    logic wrPsc;
    logic wrRld;
    logic forceUpd;
  } tmrStrobe_t;
endpackage

// File: rtl/trig_timer_dp.sv
module trig_timer_dp
  import trig_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cmpVal,
  output logic [CNT_W-1:0]  cntOut,
  output logic [PSC_W-1:0]  pscPendOut,
  output logic [CNT_W-1:0]  rldPendOut,
  output logic              updEvt,
  output logic              cmpEvt
);
  logic [PSC_W-1:0] pscPend, pscAct, prescCnt;
  logic [CNT_W-1:0] rldPend, rldAct, cntQ, cntNext;
  logic tick, wrap, cntLoad;

  assign tick    = stb.run && (prescCnt == pscAct);
  assign wrap    = tick && (cntQ == rldAct);
  assign cntLoad = stb.forceUpd || tick;
  assign updEvt  = stb.forceUpd || wrap;

  always_comb begin
    if (stb.forceUpd)  cntNext = '0;
    else if (wrap)     cntNext = '0;
    else if (tick)     cntNext = cntQ + 1'b1;
    else               cntNext = cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      cntQ     <= '0;
      cmpEvt   <= 1'b0;
    end else begin
      cntQ   <= cntNext;
      cmpEvt <= cntLoad && (cntNext == cmpVal);
      if (stb.forceUpd)  prescCnt <= '0;
      else if (tick)     prescCnt <= '0;
      else if (stb.run)  prescCnt <= prescCnt + 1'b1;
    end
  end

  // shadow registers: an immediate write wins over a reload on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscPend <= '0;
      pscAct  <= '0;
      rldPend <= '0;
      rldAct  <= '0;
    end else begin
      if (updEvt) begin
        pscAct <= pscPend;
        rldAct <= rldPend;
      end
      if (stb.wrPsc) begin
        pscPend <= wrData[PSC_W-1:0];
        if (!stb.pscPre) pscAct <= wrData[PSC_W-1:0];
      end
      if (stb.wrRld) begin
        rldPend <= wrData[CNT_W-1:0];
        if (!stb.rldPre) rldAct <= wrData[CNT_W-1:0];
      end
    end
  end

  assign cntOut     = cntQ;
  assign pscPendOut = pscPend;
  assign rldPendOut = rldPend;

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.forceUpd) |=> $stable(cntQ));
  assert_force_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceUpd |=> (cntQ == '0 && prescCnt == '0));
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && prescCnt == pscAct && cntQ == rldAct) |=> cntQ == '0);
  assert_preload_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rldPre && stb.wrRld && !updEvt) |=> $stable(rldAct));
  assert_psc_preload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pscPre && stb.wrPsc && !updEvt) |=> $stable(pscAct));
endmodule

// File: rtl/trig_timer_sel.sv
module trig_timer_sel #(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SEL_W-1:0]      sel,
  input  logic [(1<<SEL_W)-1:0] src,
  output logic                  trig
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trig <= 1'b0;
    else       trig <= src[sel];
  end
endmodule

// File: rtl/trig_timer_ctrl.sv
module trig_timer_ctrl
  import trig_timer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter bit HAS_SEL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [REF_N-1:0]  ocRef,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [PSC_W-1:0]  pscPend,
  input  logic [CNT_W-1:0]  rldPend,
  input  logic              updEvt,
  input  logic              cmpEvt,
  output tmrStrobe_t        stb,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              trgo,
  output logic              trgo2
);
  localparam int SEL1_W = 3;
  localparam int SEL2_W = 4;

  logic             runQ, rldPreQ, pscPreQ;
  logic [SEL1_W-1:0] mode1Q;
  logic [SEL2_W-1:0] mode2Q;
  logic [CNT_W-1:0] cmpQ;
  logic [REF_N-1:0] refPrev, refRise, refFall;
  logic [SRC_N-1:0] src;
  logic wrCtrl, wrMode, wrCmp;

  assign wrCtrl = wrEn && (wrAddr == A_CTRL);
  assign wrMode = wrEn && (wrAddr == A_MODE);
  assign wrCmp  = wrEn && (wrAddr == A_CMP);

  assign stb.run      = runQ;
  assign stb.rldPre   = rldPreQ;
  assign stb.pscPre   = pscPreQ;
  assign stb.wrPsc    = wrEn && (wrAddr == A_PSC);
  assign stb.wrRld    = wrEn && (wrAddr == A_RLD);
  assign stb.forceUpd = wrEn && (wrAddr == A_CMD) && wrData[0];
  assign cmpVal       = cmpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      rldPreQ <= 1'b0;
      pscPreQ <= 1'b0;
      mode1Q  <= '0;
      cmpQ    <= '0;
      refPrev <= '0;
    end else begin
      refPrev <= ocRef;
      if (wrCtrl) begin
        runQ    <= wrData[0];
        rldPreQ <= wrData[1];
        pscPreQ <= wrData[2];
      end
      if (wrMode) mode1Q <= wrData[2:0];
      if (wrCmp)  cmpQ   <= wrData[CNT_W-1:0];
    end
  end

  assign refRise = ocRef & ~refPrev;
  assign refFall = ~ocRef & refPrev;

  // shared source list, indexed by selector code
  always_comb begin
    src[0]  = stb.forceUpd;
    src[1]  = runQ;
    src[2]  = updEvt;
    src[3]  = cmpEvt;
    src[4]  = ocRef[0];
    src[5]  = ocRef[1];
    src[6]  = ocRef[2];
    src[7]  = ocRef[3];
    src[8]  = ocRef[4];
    src[9]  = ocRef[5];
    src[10] = refRise[3];
    src[11] = refRise[5];
    src[12] = refRise[3] | refRise[5];
    src[13] = refRise[3] | refFall[5];
    src[14] = refRise[4] | refRise[5];
    src[15] = refRise[4] | refFall[5];
  end

  trig_timer_sel #(.SEL_W(SEL1_W)) uSel1 (
    .clk(clk), .rstN(rstN), .sel(mode1Q),
    .src(src[(1<<SEL1_W)-1:0]), .trig(trgo)
  );

  generate
    if (HAS_SEL2) begin : gSel2
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       mode2Q <= '0;
        else if (wrMode) mode2Q <= wrData[7:4];
      end
      trig_timer_sel #(.SEL_W(SEL2_W)) uSel2 (
        .clk(clk), .rstN(rstN), .sel(mode2Q), .src(src), .trig(trgo2)
      );
    end else begin : gNoSel2
      assign mode2Q = '0;
      assign trgo2  = 1'b0;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL: rdData[2:0] = {pscPreQ, rldPreQ, runQ};
      A_MODE: begin
        rdData[2:0] = mode1Q;
        rdData[7:4] = mode2Q;
      end
      A_PSC:  rdData = DATA_W'(pscPend);
      A_RLD:  rdData = DATA_W'(rldPend);
      A_CMP:  rdData = DATA_W'(cmpQ);
      A_CNT:  rdData = DATA_W'(cntIn);
      default: rdData = '0;
    endcase
  end

  assert_enable_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode1Q == 3'd1) |=> (trgo == $past(runQ)));
  assert_reset_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode1Q == 3'd0 && !stb.forceUpd) |=> !trgo);
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter bit HAS_SEL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [5:0]        ocRef,
  output logic [CNT_W-1:0]  count,
  output logic              trgo,
  output logic              trgo2
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] cmpVal, rldPend;
  logic [PSC_W-1:0] pscPend;
  logic             updEvt, cmpEvt;

  trig_timer_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_SEL2(HAS_SEL2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ocRef(ocRef), .cntIn(count),
    .pscPend(pscPend), .rldPend(rldPend), .updEvt(updEvt), .cmpEvt(cmpEvt),
    .stb(stb), .cmpVal(cmpVal), .trgo(trgo), .trgo2(trgo2)
  );

  trig_timer_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .cmpVal(cmpVal),
    .cntOut(count), .pscPendOut(pscPend), .rldPendOut(rldPend),
    .updEvt(updEvt), .cmpEvt(cmpEvt)
  );
endmodule

// File: tb/tb_trig_timer.sv
module tb_trig_timer;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [5:0] ocRef = '0;
  logic [DW-1:0] rdData, rdData2;
  logic [CW-1:0] count, count2;
  logic trgo, trgo2, trgoB, trgo2B;

  int tests = 0;
  int fails = 0;
  bit checkEn = 1'b0;

  always #5 clk = ~clk;

  trig_timer #(.DATA_W(DW), .CNT_W(CW), .PSC_W(PW), .HAS_SEL2(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ocRef(ocRef), .count(count),
    .trgo(trgo), .trgo2(trgo2));

  trig_timer #(.DATA_W(DW), .CNT_W(CW), .PSC_W(PW), .HAS_SEL2(1'b0)) dutNoSel2 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData2), .ocRef(ocRef), .count(count2),
    .trgo(trgoB), .trgo2(trgo2B));

  // ---------------- reference model built from the requirements ----------
  logic mRun, mRldPre, mPscPre, mCmpE, mTrgo, mTrgo2;
  logic [2:0] mMode1;
  logic [3:0] mMode2;
  logic [CW-1:0] mCnt, mRldA, mRldP, mCmp;
  logic [PW-1:0] mPresc, mPscA, mPscP;
  logic [5:0] mPrev;

  function automatic logic srcOf(input logic [3:0] s, input logic frc, input logic up,
                                 input logic run, input logic ce, input logic [5:0] lv,
                                 input logic [5:0] r, input logic [5:0] f);
    case (s)
      4'd0: return frc;
      4'd1: return run;
      4'd2: return up;
      4'd3: return ce;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return lv[s - 4];
      4'd10: return r[3];
      4'd11: return r[5];
      4'd12: return r[3] | r[5];
      4'd13: return r[3] | f[5];
      4'd14: return r[4] | r[5];
      default: return r[4] | f[5];
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] s);
    if (s == 0) return "R5";
    if (s == 1) return "R6";
    if (s == 2) return "R2";
    if (s == 3) return "R8";
    if (s < 8)  return "R7";
    if (s < 12) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mRldPre = 0; mPscPre = 0; mCmpE = 0; mTrgo = 0; mTrgo2 = 0;
      mMode1 = 0; mMode2 = 0; mCnt = 0; mRldA = 0; mRldP = 0; mCmp = 0;
      mPresc = 0; mPscA = 0; mPscP = 0; mPrev = 0;
    end else begin
      logic frc, tk, ov, up, nCmpE;
      logic [5:0] r, f;
      logic [CW-1:0] nCnt, nRldA;
      logic [PW-1:0] nPresc, nPscA;
      frc = wrEn && wrAddr == 3'd5 && wrData[0];
      tk  = mRun && (mPresc == mPscA);
      ov  = tk && (mCnt == mRldA);
      up  = frc || ov;
      r = ocRef & ~mPrev;
      f = ~ocRef & mPrev;
      mTrgo  = srcOf({1'b0, mMode1}, frc, up, mRun, mCmpE, ocRef, r, f);
      mTrgo2 = srcOf(mMode2, frc, up, mRun, mCmpE, ocRef, r, f);
      if (frc || ov) nCnt = '0;
      else if (tk)   nCnt = mCnt + 1'b1;
      else           nCnt = mCnt;
      nCmpE = (frc || tk) && (nCnt == mCmp);
      if (frc || tk) nPresc = '0;
      else if (mRun) nPresc = mPresc + 1'b1;
      else           nPresc = mPresc;
      nPscA = up ? mPscP : mPscA;
      nRldA = up ? mRldP : mRldA;
      if (wrEn && wrAddr == 3'd2) begin
        if (!mPscPre) nPscA = wrData[PW-1:0];
        mPscP = wrData[PW-1:0];
      end
      if (wrEn && wrAddr == 3'd3) begin
        if (!mRldPre) nRldA = wrData[CW-1:0];
        mRldP = wrData[CW-1:0];
      end
      if (wrEn && wrAddr == 3'd0) begin
        mRun = wrData[0]; mRldPre = wrData[1]; mPscPre = wrData[2];
      end
      if (wrEn && wrAddr == 3'd1) begin
        mMode1 = wrData[2:0]; mMode2 = wrData[7:4];
      end
      if (wrEn && wrAddr == 3'd4) mCmp = wrData[CW-1:0];
      mCnt = nCnt; mCmpE = nCmpE; mPresc = nPresc; mPscA = nPscA; mRldA = nRldA;
      mPrev = ocRef;
    end
  end

  function automatic logic [DW-1:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return DW'({mPscPre, mRldPre, mRun});
      3'd1: return DW'({mMode2, 1'b0, mMode1});
      3'd2: return DW'(mPscP);
      3'd3: return DW'(mRldP);
      3'd4: return DW'(mCmp);
      3'd6: return DW'(mCnt);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // lockstep comparison, sampled 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (checkEn && rstN) begin
      check(tagOf({1'b0, mMode1}), "trgo", trgo, mTrgo);
      check(tagOf(mMode2), "trgo2", trgo2, mTrgo2);
      check("R2", "count", count, mCnt);
      check((rdAddr == 3'd2) ? "R4" : "R3", "rdData", rdData, expRead(rdAddr));
      check("R11", "trgo2 without secondary", trgo2B, 1'b0);
      check("R11", "rdData without secondary", rdData2,
            (rdAddr == 3'd1) ? (expRead(3'd1) & 16'h0007) : expRead(rdAddr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rdAddr = 3'(a); #1;
      check("R1", "reset readback", rdData, 0);
    end
    check("R1", "reset trgo", trgo, 0);
    check("R1", "reset count", count, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEn = 1'b1;
    rdAddr = 3'd6;

    // R2 period: prescale 2, reload 4, update mode -> 15 cycles
    wr(3'd2, 16'd2); wr(3'd3, 16'd4); wr(3'd1, 16'h0022); wr(3'd0, 16'd1);
    do step(); while (!trgo);
    gap = 0;
    do begin step(); gap++; end while (!trgo && gap < 100);
    check("R2", "update period", gap, 15);

    // R3 reload preload: pending value read back, active waits for update
    wr(3'd0, 16'd3); wr(3'd3, 16'd9); wr(3'd5, 16'd1); wr(3'd3, 16'd2);
    rdAddr = 3'd3; #1;
    check("R3", "pending reload read", rdData, 2);
    rdAddr = 3'd6;
    repeat (80) step();

    // R4 prescale preload and immediate write of a smaller prescale
    wr(3'd0, 16'd5); wr(3'd2, 16'd3); repeat (30) step();
    wr(3'd0, 16'd1); wr(3'd2, 16'd0); repeat (40) step();

    // R6 freeze and enable level
    wr(3'd1, 16'h0011); wr(3'd0, 16'd0);
    begin
      logic [CW-1:0] held;
      held = count;
      repeat (6) step();
      check("R6", "frozen count", count, held);
      check("R6", "enable level trgo", trgo, 0);
    end

    // R8 compare pulse
    wr(3'd4, 16'd3); wr(3'd1, 16'h0033); wr(3'd3, 16'd6); wr(3'd5, 16'd1);
    wr(3'd0, 16'd1); repeat (40) step();

    // R11 discovery
    wr(3'd1, 16'h00F2);
    rdAddr = 3'd1; #1;
    check("R11", "mode readback without secondary", rdData2, 16'h0002);
    check("R9", "mode readback with secondary", rdData, 16'h00F2);

    // R7 R9 R10 reference codes swept with toggling references
    for (int m = 4; m < 16; m++) begin
      wr(3'd1, DW'({m[3:0], 1'b0, m[2:0]}));
      for (int k = 0; k < 12; k++) begin
        @(negedge clk); ocRef = 6'($urandom);
      end
    end

    // R2 full-scale reload with no prescale
    wr(3'd1, 16'h0022); wr(3'd0, 16'd0); wr(3'd2, 16'd0); wr(3'd3, 16'd255);
    wr(3'd5, 16'd1); wr(3'd0, 16'd1);
    rdAddr = 3'd6;
    repeat (600) step();

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      int pick;
      @(negedge clk);
      pick = $urandom_range(99);
      wrEn = 1'b1;
      if (pick < 6)       begin wrAddr = 3'd0; wrData = DW'({$urandom_range(7)} | (pick < 5)); end
      else if (pick < 10) begin wrAddr = 3'd1; wrData = DW'($urandom_range(255)); end
      else if (pick < 16) begin wrAddr = 3'd2; wrData = DW'($urandom_range(3)); end
      else if (pick < 23) begin wrAddr = 3'd3; wrData = DW'($urandom_range(12)); end
      else if (pick < 27) begin wrAddr = 3'd4; wrData = DW'($urandom_range(12)); end
      else if (pick < 30) begin wrAddr = 3'd5; wrData = DW'($urandom_range(1)); end
      else wrEn = 1'b0;
      if ($urandom_range(2) == 0) ocRef = 6'($urandom);
      rdAddr = 3'($urandom_range(7));
    end
    @(negedge clk);
    wrEn = 1'b0;
    repeat (4) step();
    finishRun();
  end
endmodule